// File: doc/BRIEF.md
# Byte-Wide Programmable ROM with Control-Pin Mode Decode

This block is a cycle-based model of a byte-wide, UV-erasable style programmable memory. Four control inputs select the operating mode: an active-low chip select that also serves as the program strobe, an active-low output gate, a flag for the programming supply, and a flag for high voltage on address bit 9. The mode decides whether the array is read and the byte driven, whether the bus floats, or whether a byte is programmed. The array starts with every bit at one. Programming can only turn ones into zeros, and an erase input sets the whole array back to ones.

Timing is counted in clock cycles. A read becomes valid a set number of cycles after the address or the select changes. The output gate has a shorter delay of its own. After a disable, the bus keeps its last byte for a set number of cycles before it floats. The bus is split into a data vector and a drive-enable, so the surrounding logic builds the tri-state. `ADDR_W` sets the depth. Its default of 11 keeps elaboration small, and a value of 16 gives the full 65,536-byte array. `ADDR_W` must be at least 10 so that bit 9 exists.

Top module: `eprom_mode_array`

## Requirements
- R1: With the supply flag low, the high-voltage flag low, and `ce_n` and `oe_n` both low, the block drives the stored byte at `addr` on `dout` with `dout_en` at 1.
- R2: With the supply flag low and `ce_n` high, the block is in standby and `dout_en` settles to 0 whatever the level of `oe_n`.
- R3: With the supply flag low, `ce_n` low and `oe_n` high, `dout_en` settles to 0.
- R4: With the supply flag high, `ce_n` high and `oe_n` low (verify), the block drives the stored byte at `addr`.
- R5: In a read with `a9_hv` high, `dout` shows 0x8F when `addr[0]` is 0 and 0x85 when `addr[0]` is 1, whatever the array holds.
- R6: A program operation stores the bitwise AND of `din` and the old byte, so a bit can only go from 1 to 0.
- R7: Programming happens only at the first clock edge at which the supply flag is high, `ce_n` is low and `oe_n` is high. Holding that state writes one byte, and later changes to `din` during the same pulse are ignored.
- R8: With the supply flag high and `ce_n` high with `oe_n` high, or with both low, nothing is written and `dout_en` settles to 0.
- R9: From the edge that first samples a read request, a new `addr` or a new `a9_hv`, the new byte appears after `ACC_CYC` edges (default 3). If the bus was driven before, it keeps the previous byte until then.
- R10: If `oe_n` falls up to `ACC_CYC - OE_CYC` cycles after `ce_n` falls (default 2), the byte still appears `ACC_CYC` edges after `ce_n` was sampled low.
- R11: After the edge that first samples a disable, `dout_en` stays 1 with the last byte for `DF_CYC` edges (default 2) and then goes to 0.
- R12: A high `erase` at a clock edge sets every byte to 0xFF and wins over a write at the same edge.
- R13: `rst_n` low at once forces `dout_en` and `dout` to 0 and sets every byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to be programmed |
| ce_n | input | 1 | Active-low chip select and program strobe |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage on address bit 9 (identification) |
| erase | input | 1 | Sets the whole array to 0xFF |
| dout | output | 8 | Read data, 0 when floated |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The hardest cases to reach are the ones where two timing windows overlap. In one, the bus is still holding the old byte from the float delay while the access timer restarts for a new address. In the other, `oe_n` falls late but still inside the access window. The bench reaches both by changing one input at a known negative edge after a settled state, then sampling the bus at each edge that follows. It also tries to write twice within one program pulse by changing `din` while `ce_n` is held low, and it raises erase together with the start of a program pulse.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_BIT = 9;
  localparam logic [BYTE_W-1:0] ID_MAKER  = 8'h8F;
  localparam logic [BYTE_W-1:0] ID_DEVICE = 8'h85;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OUTOFF,
    MD_READ,
    MD_IDENT,
    MD_PROGRAM,
    MD_VERIFY,
    MD_INHIBIT
  } mode_t;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_t mode
);
  always_comb begin
    if (!vpp_hi) begin
      if (ce_n)       mode = MD_STANDBY;
      else if (oe_n)  mode = MD_OUTOFF;
      else if (a9_hv) mode = MD_IDENT;
      else            mode = MD_READ;
    end else begin
      if (!ce_n && oe_n)      mode = MD_PROGRAM;
      else if (ce_n && !oe_n) mode = MD_VERIFY;
      else                    mode = MD_INHIBIT;
    end
  end
endmodule

// File: rtl/eprom_sat_timer.sv
module eprom_sat_timer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic retrig,
  output logic done
);
  localparam int CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!active)                     cnt_d = '0;
    else if (retrig || cnt_q == '0)  cnt_d = CW'(1);
    else if (cnt_q < LIM)            cnt_d = cnt_q + CW'(1);
    else                             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q >= LIM) && (cnt_q != '0);
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eprom_mode_array.sv
module eprom_mode_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int ACC_CYC = 3,
  parameter int OE_CYC  = 1,
  parameter int DF_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int DFW = (DF_CYC > 0) ? $clog2(DF_CYC + 1) : 1;
  localparam logic [DFW-1:0] DF_LOAD = DFW'(DF_CYC);

  mode_t             mode, mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              a9_q;
  logic              wr_en;
  logic              acc_active, oe_active, retrig;
  logic              acc_done, oe_done;
  logic              drive;
  logic [7:0]        rd_data, live;
  logic [7:0]        hold_q, hold_d;
  logic [DFW-1:0]    flt_q, flt_d;

  eprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .a9_hv  (a9_hv),
    .mode   (mode)
  );

  // Program strobe acts on entry into program mode only
  assign wr_en      = (mode == MD_PROGRAM) && (mode_q != MD_PROGRAM);
  assign acc_active = mode inside {MD_READ, MD_IDENT, MD_OUTOFF, MD_VERIFY};
  assign oe_active  = mode inside {MD_READ, MD_IDENT, MD_VERIFY};
  assign retrig     = (addr != addr_q) || (a9_hv != a9_q);

  eprom_sat_timer #(.LIMIT(ACC_CYC)) u_acc_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (acc_active),
    .retrig (retrig),
    .done   (acc_done)
  );

  eprom_sat_timer #(.LIMIT(OE_CYC)) u_oe_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (oe_active),
    .retrig (1'b0),
    .done   (oe_done)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .wr_en   (wr_en),
    .wr_addr (addr),
    .wr_data (din),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  assign drive = (mode_q inside {MD_READ, MD_IDENT, MD_VERIFY}) && acc_done && oe_done;
  assign live  = (mode_q == MD_IDENT) ? (addr_q[0] ? ID_DEVICE : ID_MAKER) : rd_data;

  always_comb begin
    hold_d = drive ? live : hold_q;
    if (drive)             flt_d = DF_LOAD;
    else if (flt_q != '0)  flt_d = flt_q - DFW'(1);
    else                   flt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_STANDBY;
      addr_q <= '0;
      a9_q   <= 1'b0;
      hold_q <= '0;
      flt_q  <= '0;
    end else begin
      mode_q <= mode;
      addr_q <= addr;
      a9_q   <= a9_hv;
      hold_q <= hold_d;
      flt_q  <= flt_d;
    end
  end

  assign dout_en = drive || (flt_q != '0);
  assign dout    = drive ? live : ((flt_q != '0) ? hold_q : 8'h00);
endmodule

// File: rtl/eprom_mode_array_chk.sv
module eprom_mode_array_chk #(
  parameter int DF_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic vpp_hi,
  input logic dout_en,
  input logic wr_en
);
  localparam int QW = $clog2(DF_CYC + 2);
  localparam logic [QW-1:0] QLIM = QW'(DF_CYC);

  logic          out_req;
  logic [QW-1:0] quiet_q;

  assign out_req = (!vpp_hi && !ce_n && !oe_n) || (vpp_hi && ce_n && !oe_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              quiet_q <= '0;
    else if (out_req)        quiet_q <= '0;
    else if (quiet_q <= QLIM) quiet_q <= quiet_q + QW'(1);
  end

  // R11 (also R2, R3, R8): floated once the disable window has elapsed
  p_float_after_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q > QLIM) |-> !dout_en);

  // R1: drive only starts after a sampled read or verify request
  p_drive_needs_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_en) |-> $past(out_req));

  // R7: one write per program pulse
  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: no write outside the program pin state
  p_write_needs_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (vpp_hi && !ce_n && oe_n));
endmodule

bind eprom_mode_array eprom_mode_array_chk #(.DF_CYC(DF_CYC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .vpp_hi  (vpp_hi),
  .dout_en (dout_en),
  .wr_en   (wr_en)
);

// File: tb/eprom_mode_array_bench.sv
module eprom_mode_array_bench;
  logic        clk;
  logic        rst_n;
  logic [10:0] addr;
  logic [7:0]  din;
  logic        ce_n, oe_n, vpp_hi, a9_hv, erase;
  logic [7:0]  dout;
  logic        dout_en;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  eprom_mode_array u_eprom_mode_array (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic        ce_n;
    logic        oe_n;
    logic        vpp;
    logic        a9;
    logic [10:0] addr;
    logic [7:0]  din;
    logic        en;
    logic [7:0]  q;
    logic [3:0]  req;
  } vec_t;

  // Settled-state vectors: ce_n, oe_n, vpp, a9, addr, din, expected enable, expected byte, requirement
  localparam vec_t VEC [17] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 11'h010, 8'h00, 1'b0, 8'h00, 4'd2},  // R2 standby, oe low
    '{1'b1, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00, 1'b0, 8'h00, 4'd2},  // R2 standby, oe high
    '{1'b0, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00, 1'b0, 8'h00, 4'd3},  // R3 output gated off
    '{1'b0, 1'b0, 1'b0, 1'b0, 11'h010, 8'h00, 1'b1, 8'hFF, 4'd1},  // R1 erased byte
    '{1'b0, 1'b0, 1'b0, 1'b1, 11'h000, 8'h00, 1'b1, 8'h8F, 4'd5},  // R5 maker byte
    '{1'b0, 1'b0, 1'b0, 1'b1, 11'h001, 8'h00, 1'b1, 8'h85, 4'd5},  // R5 device byte
    '{1'b0, 1'b1, 1'b1, 1'b0, 11'h010, 8'hA5, 1'b0, 8'h00, 4'd7},  // R7 program pulse
    '{1'b1, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00, 1'b1, 8'hA5, 4'd4},  // R4 verify
    '{1'b0, 1'b1, 1'b1, 1'b0, 11'h010, 8'h3C, 1'b0, 8'h00, 4'd6},  // R6 second pulse
    '{1'b1, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00, 1'b1, 8'h24, 4'd6},  // R6 A5 & 3C
    '{1'b1, 1'b1, 1'b1, 1'b0, 11'h010, 8'h00, 1'b0, 8'h00, 4'd8},  // R8 inhibit
    '{1'b1, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00, 1'b1, 8'h24, 4'd8},  // R8 nothing written
    '{1'b0, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00, 1'b0, 8'h00, 4'd8},  // R8 both low
    '{1'b1, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00, 1'b1, 8'h24, 4'd8},  // R8 still unchanged
    '{1'b0, 1'b0, 1'b0, 1'b0, 11'h010, 8'h00, 1'b1, 8'h24, 4'd1},  // R1 normal read
    '{1'b0, 1'b0, 1'b0, 1'b1, 11'h010, 8'h00, 1'b1, 8'h8F, 4'd5},  // R5 overrides array
    '{1'b0, 1'b0, 1'b0, 1'b0, 11'h011, 8'h00, 1'b1, 8'hFF, 4'd1}   // R1 untouched byte
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic en_exp, input logic [7:0] q_exp);
    checks++;
    if (dout_en !== en_exp || (en_exp && dout !== q_exp)) begin
      errs++;
      $display("FAIL %s: en=%b dout=%02h expected en=%b dout=%02h", req, dout_en, dout, en_exp, q_exp);
    end
  endtask

  task automatic pins(input logic c, input logic o, input logic v, input logic a,
                      input logic [10:0] ad, input logic [7:0] d);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = a; addr = ad; din = d;
  endtask

  initial begin
    rst_n = 1'b0; erase = 1'b0;
    pins(1'b1, 1'b1, 1'b0, 1'b0, 11'h000, 8'h00);
    #1;
    check("R13", 1'b0, 8'h00);
    checks++;
    if (dout !== 8'h00) begin
      errs++;
      $display("FAIL R13: dout=%02h expected 00", dout);
    end
    tick(2);
    rst_n = 1'b1;
    tick(2);
    check("R2", 1'b0, 8'h00);

    for (int i = 0; i < 17; i++) begin
      pins(VEC[i].ce_n, VEC[i].oe_n, VEC[i].vpp, VEC[i].a9, VEC[i].addr, VEC[i].din);
      tick(6);
      check($sformatf("R%0d", VEC[i].req), VEC[i].en, VEC[i].q);
    end

    // R9: access count from a standby start
    pins(1'b1, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00); tick(6);
    pins(1'b0, 1'b0, 1'b0, 1'b0, 11'h010, 8'h00);
    tick(2); check("R9", 1'b0, 8'h00);
    tick(1); check("R9", 1'b1, 8'h24);

    // R11: float delay after the output gate rises
    oe_n = 1'b1;
    tick(1); check("R11", 1'b1, 8'h24);
    tick(1); check("R11", 1'b1, 8'h24);
    tick(1); check("R11", 1'b0, 8'h00);

    // R10: late output gate inside the window
    pins(1'b1, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00); tick(6);
    pins(1'b0, 1'b1, 1'b0, 1'b0, 11'h010, 8'h00);
    tick(2); oe_n = 1'b0;
    check("R10", 1'b0, 8'h00);
    tick(1); check("R10", 1'b1, 8'h24);

    // R9: address change restarts access, old byte held meanwhile
    tick(4);
    addr = 11'h011;
    tick(2); check("R9", 1'b1, 8'h24);
    tick(1); check("R9", 1'b1, 8'hFF);

    // R7: din changes while the pulse is held are ignored
    pins(1'b0, 1'b1, 1'b1, 1'b0, 11'h020, 8'hF0);
    tick(1); din = 8'h0F;
    tick(4);
    pins(1'b1, 1'b0, 1'b1, 1'b0, 11'h020, 8'h00);
    tick(6); check("R7", 1'b1, 8'hF0);

    // R12: erase at the same edge as a program entry wins
    pins(1'b0, 1'b1, 1'b1, 1'b0, 11'h010, 8'h00); erase = 1'b1;
    tick(1); erase = 1'b0;
    tick(2);
    pins(1'b1, 1'b0, 1'b1, 1'b0, 11'h010, 8'h00);
    tick(6); check("R12", 1'b1, 8'hFF);
    addr = 11'h020;
    tick(6); check("R12", 1'b1, 8'hFF);

    // R13: reset during a drive, array back to erased
    pins(1'b0, 1'b1, 1'b1, 1'b0, 11'h030, 8'h00); tick(2);
    pins(1'b0, 1'b0, 1'b0, 1'b0, 11'h030, 8'h00);
    tick(6); check("R6", 1'b1, 8'h00);
    rst_n = 1'b0; #1;
    check("R13", 1'b0, 8'h00);
    tick(2); rst_n = 1'b1;
    tick(6); check("R13", 1'b1, 8'hFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule